// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Block

This block sits between a processor bus and a byte-wide serial link. It gives software four word-spaced registers: a receive data port, a transmit data port, a status word and a control word. It also drives one level interrupt line. Bytes from an external deserializer arrive as single-cycle strobes and wait in an eight-entry first-in first-out buffer until software reads them. A write to the transmit port goes out at once as a one-cycle strobe with the byte, to an external serializer that is assumed to keep up. Baud timing and bit framing live outside this block.

Bus accesses are single-cycle requests. A read answers one clock later on a registered response port. One interrupt-pending flag collects two kinds of event: data sitting in the receive buffer, and any write to the transmit port. A control bit gates that flag onto the interrupt line.

Top module: `uart_regblock`

## Requirements
- R1: The register index is the byte address shifted right by two (address bits 1:0 are ignored). Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Indices 4 and up read as zero and ignore writes. Every read gives `rsp_valid` high for one cycle, with `rsp_rdata` in the cycle after the request. Only the low byte of a write is used, and every register reads back zero-extended to the bus width.
- R2: The status byte has these bits. Bit 0 is set when the receive buffer is non-empty. Bit 1 is set when it holds 8 bytes. Bit 2 (transmit empty) always reads 1. Bit 3 (transmit full) always reads 0. Bit 4 is the interrupt-pending flag. Bits 7:5 (error flags) read 0. A read returns the state from before that cycle's update.
- R3: The receive buffer holds up to 8 bytes. A read of index 0 returns the oldest stored byte and removes it. Bytes come out in arrival order. An arrival and a removal in the same cycle both take effect.
- R4: A byte whose `rx_valid` strobe comes while 8 bytes are stored is dropped, and the count and contents stay as they were. `rx_ready` is high exactly when fewer than 8 bytes are stored.
- R5: A read of index 0 while the buffer is empty returns the byte in the slot that the next arrival will fill, and the count stays zero.
- R6: A write to control stores the low byte, and it reads back. If bit 1 of that byte is set, the receive buffer is emptied in that cycle, and a byte that arrives in the same cycle is discarded.
- R7: A write to transmit data gives `tx_valid` high for exactly one cycle, in the cycle after the request, with `tx_data` equal to the written low byte. That byte also reads back from index 1.
- R8: Two things set the interrupt-pending flag: a write to transmit data, and a non-empty receive buffer at the end of a cycle. A read of status clears the flag, unless the buffer is still non-empty after that cycle.
- R9: `irq` is high exactly when the pending flag is set and control bit 4 is set.
- R10: A write to the status index changes no state. Status reads back as it would have without the write.
- R11: After reset, status reads 0x04, control and transmit data read 0, `irq` and `tx_valid` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data; low byte used |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Buffer has room |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases involve the buffer's edges meeting other events in the same cycle. These are: an arrival that lands on a full buffer together with a pop, an arrival that coincides with a control write that flushes the buffer, and a read of an empty buffer, which exposes a stale slot whose value depends on the whole history of arrivals since the last flush. The stimulus first drives ten back-to-back arrivals so that the buffer overflows. It then issues pops and arrivals in the same cycle at full, at empty and in between, and flushes with a byte arriving in the same cycle. The bench model tracks stored bytes and slot history behaviourally, so stale reads can be predicted.

// File: rtl/uartr_pkg.sv
package uartr_pkg;

    typedef enum logic [1:0] {
        IDX_RXD  = 2'd0,
        IDX_TXD  = 2'd1,
        IDX_STAT = 2'd2,
        IDX_CTRL = 2'd3
    } reg_idx_e;

    localparam int NUM_REGS   = 4;

    localparam int ST_RXVLD   = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;

    localparam int CT_TXCLR   = 0;
    localparam int CT_RXCLR   = 1;
    localparam int CT_IEN     = 4;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] txd;
        logic       pend;
        logic       tx_vld;
        logic       rsp_vld;
        logic [7:0] rsp;
    } regs_t;

    localparam regs_t REGS_RST = '0;

endpackage

// File: rtl/uartr_decode.sv
module uartr_decode #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]            addr,
    output logic [uartr_pkg::NUM_REGS-1:0] sel
);
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0] idx;
    logic          in_map;
    logic          unused_low;

    assign idx        = addr[ADDR_W-1:2];
    assign unused_low = ^addr[1:0];
    assign in_map     = ((idx >> 2) == '0);

    for (genvar k = 0; k < uartr_pkg::NUM_REGS; k++) begin : g_sel
        assign sel[k] = in_map && (idx[1:0] == 2'(k));
    end
endmodule

// File: rtl/uartr_rxbuf.sv
module uartr_rxbuf #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [7:0]                 push_data,
    input  logic                       pop,
    input  logic                       flush,
    output logic [7:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [$clog2(DEPTH+1)-1:0] count_next,
    output logic                       full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ok = push && !flush && (cnt_q < CW'(DEPTH));
        pop_ok  = pop && !flush && (cnt_q != '0);
        wr_d    = wr_q;
        rd_d    = rd_q;
        cnt_d   = cnt_q;
        if (flush) begin
            wr_d  = '0;
            rd_d  = '0;
            cnt_d = '0;
        end else begin
            if (push_ok) wr_d = wrap_inc(wr_q);
            if (pop_ok)  rd_d = wrap_inc(rd_q);
            cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q] <= push_data;
    end

    assign head       = mem[rd_q];
    assign count      = cnt_q;
    assign count_next = cnt_d;
    assign full       = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
    import uartr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    regs_t            st_d, st_q;
    logic [NUM_REGS-1:0] sel;
    logic             rd, wr, pop, flush;
    logic [7:0]       head, stat_byte, wbyte, rd_val;
    logic [CW-1:0]    rx_count, rx_count_nx;
    logic             rx_full;
    logic             pend_flag, ctrl_ien;
    logic             unused_hi;

    assign unused_hi = ^req_wdata[DATA_W-1:8];
    assign wbyte     = req_wdata[7:0];
    assign rd        = req_valid && !req_write;
    assign wr        = req_valid && req_write;
    assign pop       = rd && sel[IDX_RXD];
    assign flush     = wr && sel[IDX_CTRL] && wbyte[CT_RXCLR];

    uartr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    uartr_rxbuf #(.DEPTH(DEPTH)) u_rxb (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_valid),
        .push_data  (rx_data),
        .pop        (pop),
        .flush      (flush),
        .head       (head),
        .count      (rx_count),
        .count_next (rx_count_nx),
        .full       (rx_full)
    );

    always_comb begin
        stat_byte              = '0;
        stat_byte[ST_RXVLD]    = (rx_count != '0);
        stat_byte[ST_RXFULL]   = rx_full;
        stat_byte[ST_TXEMPTY]  = 1'b1;
        stat_byte[ST_TXFULL]   = 1'b0;
        stat_byte[ST_PEND]     = st_q.pend;

        rd_val = '0;
        if (sel[IDX_RXD])  rd_val = head;
        if (sel[IDX_TXD])  rd_val = st_q.txd;
        if (sel[IDX_STAT]) rd_val = stat_byte;
        if (sel[IDX_CTRL]) rd_val = st_q.ctrl;

        st_d         = st_q;
        st_d.tx_vld  = 1'b0;
        st_d.rsp_vld = rd;
        if (rd) st_d.rsp = rd_val;

        if (wr && sel[IDX_TXD]) begin
            st_d.txd    = wbyte;
            st_d.tx_vld = 1'b1;
        end
        if (wr && sel[IDX_CTRL]) st_d.ctrl = wbyte;

        if (rd && sel[IDX_STAT]) st_d.pend = 1'b0;
        if ((wr && sel[IDX_TXD]) || (rx_count_nx != '0)) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    assign pend_flag = st_q.pend;
    assign ctrl_ien  = st_q.ctrl[CT_IEN];
    assign irq       = pend_flag && ctrl_ien;
    assign rx_ready  = !rx_full;
    assign tx_valid  = st_q.tx_vld;
    assign tx_data   = st_q.txd;
    assign rsp_valid = st_q.rsp_vld;
    assign rsp_rdata = {{(DATA_W-8){1'b0}}, st_q.rsp};
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [DATA_W-1:0]          req_wdata,
    input logic                       rx_valid,
    input logic                       tx_valid,
    input logic [7:0]                 tx_data,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       pend_flag,
    input logic                       ctrl_ien
);
    localparam int CW = $clog2(DEPTH+1);

    logic is_tx_wr, is_ctl_wr, is_rx_rd;
    assign is_tx_wr  = req_valid && req_write  && ((req_addr >> 2) == ADDR_W'(1));
    assign is_ctl_wr = req_valid && req_write  && ((req_addr >> 2) == ADDR_W'(3));
    assign is_rx_rd  = req_valid && !req_write && ((req_addr >> 2) == ADDR_W'(0));

    assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_tx_wr |=> tx_valid && (tx_data == $past(req_wdata[7:0])));

    assert_tx_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(is_tx_wr));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_count == CW'(DEPTH) && !is_rx_rd && !is_ctl_wr)
        |=> rx_count == CW'(DEPTH));

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl_wr && req_wdata[1]) |=> rx_count == '0);

    assert_pend_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count != '0) |-> pend_flag);

    assert_irq_on_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tx_wr && ctrl_ien) |=> irq);
endmodule

bind uart_regblock uart_regblock_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rx_valid  (rx_valid),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .rx_count  (rx_count),
    .pend_flag (pend_flag),
    .ctrl_ien  (ctrl_ien)
);

// File: tb/uart_regblock_bench.sv
module uart_regblock_bench;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              irq;

    always #2 clk = ~clk;

    uart_regblock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_uart_regblock (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    int vectors = 0;
    int fails   = 0;

    // behavioural model state
    byte unsigned q[$];
    byte unsigned slot[DEPTH];
    bit           known[DEPTH];
    int           wpos = 0;
    bit           m_pend = 0;
    byte unsigned m_ctrl = 0;
    byte unsigned m_txd = 0;
    byte unsigned m_rsp = 0;
    bit           m_rsp_known = 1;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input bit w, input int addr,
                        input logic [31:0] wd, input bit rxv, input logic [7:0] rxd);
        int  idx;
        bit  rd, wr, flush, pop_ok, push_ok, txw, exp_txv, val_known;
        byte unsigned val;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = ADDR_W'(addr); req_wdata = wd;
        rx_valid = rxv; rx_data = rxd;
        idx = addr >> 2;
        rd = v && !w;
        wr = v && w;
        val = 0;
        val_known = 1;
        if (idx == 0) begin
            if (q.size() > 0) val = q[0];
            else begin val = slot[wpos]; val_known = known[wpos]; end
        end else if (idx == 1) val = m_txd;
        else if (idx == 2) val = {3'b000, m_pend, 1'b0, 1'b1, (q.size() == DEPTH), (q.size() > 0)};
        else if (idx == 3) val = m_ctrl;
        flush   = wr && idx == 3 && wd[1];
        pop_ok  = rd && idx == 0 && !flush && q.size() > 0;
        push_ok = rxv && !flush && q.size() < DEPTH;
        txw     = wr && idx == 1;
        exp_txv = txw;
        if (rd) begin m_rsp = val; m_rsp_known = val_known; end
        @(posedge clk);
        #1;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) begin
            q.push_back(rxd);
            slot[wpos] = rxd;
            known[wpos] = 1;
            wpos = (wpos + 1) % DEPTH;
        end
        if (flush) begin q.delete(); wpos = 0; end
        if (txw) m_txd = wd[7:0];
        if (wr && idx == 3) m_ctrl = wd[7:0];
        if (rd && idx == 2) m_pend = 0;
        if (txw || q.size() > 0) m_pend = 1;
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(rd));
        if (rd && m_rsp_known) chk(tag, "rsp_rdata", rsp_rdata, 32'(m_rsp));
        chk(tag, "tx_valid", 32'(tx_valid), 32'(exp_txv));
        if (exp_txv) chk(tag, "tx_data", 32'(tx_data), 32'(wd[7:0]));
        chk(tag, "irq", 32'(irq), 32'(m_pend && m_ctrl[4]));
        chk(tag, "rx_ready", 32'(rx_ready), 32'(q.size() < DEPTH));
    endtask

    task automatic wr_reg(input string tag, input int addr, input logic [31:0] d);
        step(tag, 1, 1, addr, d, 0, 8'h00);
    endtask
    task automatic rd_reg(input string tag, input int addr);
        step(tag, 1, 0, addr, 32'h0, 0, 8'h00);
    endtask
    task automatic rx_byte(input string tag, input logic [7:0] d);
        step(tag, 0, 0, 0, 32'h0, 1, d);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin slot[i] = 0; known[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values
        chk("R11", "irq_reset", 32'(irq), 32'h0);
        chk("R11", "tx_valid_reset", 32'(tx_valid), 32'h0);
        rd_reg("R11", 8);
        rd_reg("R11", 12);
        rd_reg("R11", 4);
        // R6: control write and read-back, enable interrupt
        wr_reg("R6", 12, 32'hABCD_FF10 & 32'hFFFF_FF10);
        rd_reg("R6", 12);
        // R7 / R9 / R8: transmit write sets pending, status read clears it
        wr_reg("R7", 4, 32'h0000_01A5);
        rd_reg("R7", 4);
        rd_reg("R8", 8);
        rd_reg("R8", 8);
        wr_reg("R9", 4, 32'h0000_003C);
        wr_reg("R9", 12, 32'h0000_0000);
        wr_reg("R9", 12, 32'h0000_0010);
        // R3: FIFO order with status in between
        rx_byte("R3", 8'h11);
        rx_byte("R3", 8'h22);
        rx_byte("R3", 8'h33);
        rd_reg("R2", 8);
        rd_reg("R8", 8);
        rd_reg("R3", 0);
        rd_reg("R3", 0);
        step("R3", 1, 0, 0, 32'h0, 1, 8'h44);
        rd_reg("R3", 0);
        rd_reg("R3", 0);
        rd_reg("R8", 8);
        rd_reg("R2", 8);
        // R4: overflow drops bytes
        for (int i = 0; i < 10; i++) rx_byte("R4", 8'(8'h50 + i));
        rd_reg("R2", 8);
        step("R4", 1, 0, 0, 32'h0, 1, 8'hEE);
        for (int i = 0; i < 7; i++) rd_reg("R4", 0);
        // R5: empty read returns the slot the next arrival fills
        rd_reg("R5", 0);
        rd_reg("R5", 0);
        rd_reg("R2", 8);
        step("R5", 1, 0, 0, 32'h0, 1, 8'h99);
        rd_reg("R5", 0);
        // R6: flush with a simultaneous arrival
        rx_byte("R6", 8'h61);
        rx_byte("R6", 8'h62);
        step("R6", 1, 1, 12, 32'h0000_0012, 1, 8'h63);
        rd_reg("R6", 8);
        rd_reg("R6", 12);
        rd_reg("R6", 0);
        // R10: status writes ignored
        rx_byte("R10", 8'h71);
        wr_reg("R10", 8, 32'h0000_00FF);
        rd_reg("R10", 8);
        rd_reg("R10", 0);
        wr_reg("R10", 8, 32'h0000_0000);
        rd_reg("R10", 8);
        // R1: unmapped indices and ignored low address bits
        wr_reg("R1", 20, 32'h0000_0055);
        rd_reg("R1", 20);
        rd_reg("R1", 28);
        wr_reg("R1", 13, 32'h0000_0090);
        rd_reg("R1", 14);
        rd_reg("R1", 5);
        for (int i = 0; i < 3; i++) step("R9", 0, 0, 0, 32'h0, 0, 8'h00);
        summary();
    end
endmodule